// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A four-wire test bus (test clock, mode select, serial data in, serial data out) plus an optional active-low asynchronous reset walks a sixteen-state controller. The controller reaches instruction scans and data scans. An instruction scan loads a 4-bit instruction register. A data scan shifts through the data register that the current instruction selects: a one-bit bypass stage, a 32-bit identification word, or an external boundary register.

The boundary register lives outside the block. This block hands it capture, shift and update strobes and decoded mode flags, and it takes back the boundary register's serial output. The serial output pin is registered on the falling test clock edge. Its enable is high only while a shift state is active.

Top module: `tapPort`

## Requirements
- R1: The controller state advances on every rising edge of `tck` along the standard 16-state graph, steered by `tmsIn`. Examples: from Run-Test/Idle, `tmsIn` 1,1,0,0 reaches Shift-IR. Exit1 with a 0 enters Pause. Pause with a 1 goes to Exit2. Exit2 with a 0 returns to Shift.
- R2: `trstN` low forces Test-Logic-Reset at once, without a clock. While reset is active, `irValue` equals the reset opcode and `tdoEn` is 0.
- R3: Five consecutive rising edges with `tmsIn` high reach Test-Logic-Reset from any state. The falling edge that follows loads the reset opcode into `irValue`. The reset opcode is IDCODE (0010) when `HAS_ID` is 1, and BYPASS (1111) otherwise.
- R4: In Capture-IR the instruction shift stage loads 0101. Shift-IR then moves `tdiIn` in at the MSB and presents the LSB on `tdoOut`, so the first four bits out are 1,0,1,0.
- R5: `irValue` changes only on the falling edge of `tck`, and only while in Update-IR or Test-Logic-Reset, or through `trstN`. In Update-IR it takes the shifted value.
- R6: The decoded opcodes are:
  - 0000: EXTEST, driving `modeExtest`.
  - 1100: SAMPLE/PRELOAD, driving `modeSample`.
  - 1010: INTEST, driving `modeIntest`.
  - 0010: IDCODE.
  - 1111: BYPASS.
  - Any other opcode decodes as BYPASS, with all three mode outputs at 0 and the one-bit bypass path selected.
- R7: Under BYPASS the bypass bit captures 0 in Capture-DR. In Shift-DR it takes `tdiIn`, so `tdoOut` shows a 0 and then `tdiIn` delayed by one cycle.
- R8: Under IDCODE, Capture-DR loads the word {version[31:28], part[27:12], manufacturer[11:1], 1'b1}. Shift-DR shifts it out LSB first, with `tdiIn` entering at bit 31.
- R9: On each falling edge, `tdoEn` is set to 1 exactly when the state is Shift-IR or Shift-DR. On the same edge `tdoOut` takes the selected serial bit, or 0 outside the shift states. Under EXTEST, SAMPLE and INTEST the selected bit is `bsSerialIn`.
- R10: `bsCapture`, `bsShift` and `bsUpdate` are high in Capture-DR, Shift-DR and Update-DR respectively, and only while EXTEST, SAMPLE or INTEST is the current instruction.
- R11: The Pause and Exit states leave the data shift stage unchanged, so a scan split by a pause yields the same bits as an unbroken one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tmsIn | input | 1 | Test mode select, sampled on rising `tck` |
| tdiIn | input | 1 | Serial test data in |
| bsSerialIn | input | 1 | Serial output of the external boundary register |
| tdoOut | output | 1 | Serial test data out, updated on falling `tck` |
| tdoEn | output | 1 | Output enable for `tdoOut` |
| irValue | output | 4 | Parallel (updated) instruction register |
| modeExtest | output | 1 | EXTEST instruction active |
| modeSample | output | 1 | SAMPLE/PRELOAD instruction active |
| modeIntest | output | 1 | INTEST instruction active |
| bsCapture | output | 1 | Boundary register capture strobe |
| bsShift | output | 1 | Boundary register shift strobe |
| bsUpdate | output | 1 | Boundary register update strobe |

## Verification
The bench first goes after the instruction register update timing. A design that let `irValue` follow the shift stage, or updated it on the rising edge, would change the mode flags in the middle of a scan. It also checks that an interrupted identification read and an unbroken one return the same word. A pause that kept shifting would show up as a bit-shifted word. A random walk of `tmsIn` runs against a transition model of the bench's own, and exposes a misrouted arc through the wrong `tdoEn` or strobe cycles. Unlisted opcodes and an asynchronous reset in the middle of a scan are aimed at two mistakes: a decoder that lets a stray code drive a boundary mode, and a reset that waits for a clock edge.

// File: rtl/tapPkg.sv
package tapPkg;
  localparam int IR_W = 4;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b1100;
  localparam logic [IR_W-1:0] OP_INTEST  = 4'b1010;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0010;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0101;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic inReset;
    logic capIr;
    logic shIr;
    logic updIr;
    logic capDr;
    logic shDr;
    logic updDr;
  } tapStrobe_t;

  typedef struct packed {
    logic extest;
    logic sample;
    logic intest;
    logic idcode;
    logic bypass;
  } tapMode_t;

  function automatic tapMode_t decodeOp(input logic [IR_W-1:0] op, input bit hasId);
    tapMode_t m;
    m = '0;
    case (op)
      OP_EXTEST: m.extest = 1'b1;
      OP_SAMPLE: m.sample = 1'b1;
      OP_INTEST: m.intest = 1'b1;
      OP_IDCODE: begin
        if (hasId) m.idcode = 1'b1;
        else       m.bypass = 1'b1;
      end
      default:   m.bypass = 1'b1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tapCtrl.sv
module tapCtrl
  import tapPkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tmsIn,
  output tapState_e  state,
  output tapStrobe_t strobe
);
  tapState_e stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_TLR:    stateNext = tmsIn ? ST_TLR    : ST_RTI;
      ST_RTI:    stateNext = tmsIn ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: stateNext = tmsIn ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: stateNext = tmsIn ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  stateNext = tmsIn ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: stateNext = tmsIn ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: stateNext = tmsIn ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: stateNext = tmsIn ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: stateNext = tmsIn ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: stateNext = tmsIn ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: stateNext = tmsIn ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  stateNext = tmsIn ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: stateNext = tmsIn ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: stateNext = tmsIn ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: stateNext = tmsIn ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: stateNext = tmsIn ? ST_SEL_DR : ST_RTI;
      default:   stateNext = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_TLR;
    else        state <= stateNext;
  end

  always_comb begin
    strobe.inReset = (state == ST_TLR);
    strobe.capIr   = (state == ST_CAP_IR);
    strobe.shIr    = (state == ST_SH_IR);
    strobe.updIr   = (state == ST_UPD_IR);
    strobe.capDr   = (state == ST_CAP_DR);
    strobe.shDr    = (state == ST_SH_DR);
    strobe.updDr   = (state == ST_UPD_DR);
  end
endmodule

// File: rtl/tapData.sv
module tapData
  import tapPkg::*;
#(
  parameter bit          HAS_ID     = 1'b1,
  parameter logic [3:0]  ID_VERSION = 4'h3,
  parameter logic [15:0] ID_PART    = 16'hA5C2,
  parameter logic [10:0] ID_MANUF   = 11'h2B7
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tdiIn,
  input  logic            bsSerialIn,
  input  tapStrobe_t      strobe,
  output logic [IR_W-1:0] irValue,
  output tapMode_t        mode,
  output logic            boundarySel,
  output logic            tdoOut,
  output logic            tdoEn
);
  localparam logic [IR_W-1:0] RESET_OP = HAS_ID ? OP_IDCODE : OP_BYPASS;
  localparam logic [ID_W-1:0] ID_WORD  = {ID_VERSION, ID_PART, ID_MANUF, 1'b1};

  logic [IR_W-1:0] irShift;
  logic            bypassBit;
  logic            idBit;
  logic            drBit;
  logic            serialBit;

  // instruction shift stage, rising edge
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            irShift <= '0;
    else if (strobe.capIr) irShift <= IR_CAPTURE;
    else if (strobe.shIr)  irShift <= {tdiIn, irShift[IR_W-1:1]};
  end

  // instruction parallel stage, falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)              irValue <= RESET_OP;
    else if (strobe.inReset) irValue <= RESET_OP;
    else if (strobe.updIr)   irValue <= irShift;
  end

  assign mode        = decodeOp(irValue, HAS_ID);
  assign boundarySel = mode.extest | mode.sample | mode.intest;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            bypassBit <= 1'b0;
    else if (strobe.capDr) bypassBit <= 1'b0;
    else if (strobe.shDr)  bypassBit <= tdiIn;
  end

  generate
    if (HAS_ID) begin : g_id
      logic [ID_W-1:0] idShift;
      always_ff @(posedge tck or negedge trstN) begin
        if (!trstN)                         idShift <= '0;
        else if (strobe.capDr && mode.idcode) idShift <= ID_WORD;
        else if (strobe.shDr && mode.idcode)  idShift <= {tdiIn, idShift[ID_W-1:1]};
      end
      assign idBit = idShift[0];
    end else begin : g_noId
      assign idBit = 1'b0;
    end
  endgenerate

  always_comb begin
    if (mode.idcode)      drBit = idBit;
    else if (mode.bypass) drBit = bypassBit;
    else                  drBit = bsSerialIn;
  end

  always_comb begin
    if (strobe.shIr)      serialBit = irShift[0];
    else if (strobe.shDr) serialBit = drBit;
    else                  serialBit = 1'b0;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdoOut <= 1'b0;
      tdoEn  <= 1'b0;
    end else begin
      tdoOut <= serialBit;
      tdoEn  <= strobe.shIr | strobe.shDr;
    end
  end
endmodule

// File: rtl/tapPort.sv
module tapPort
  import tapPkg::*;
#(
  parameter bit          HAS_ID     = 1'b1,
  parameter logic [3:0]  ID_VERSION = 4'h3,
  parameter logic [15:0] ID_PART    = 16'hA5C2,
  parameter logic [10:0] ID_MANUF   = 11'h2B7
) (
  input  logic       tck,
  input  logic       trstN,
  input  logic       tmsIn,
  input  logic       tdiIn,
  input  logic       bsSerialIn,
  output logic       tdoOut,
  output logic       tdoEn,
  output logic [3:0] irValue,
  output logic       modeExtest,
  output logic       modeSample,
  output logic       modeIntest,
  output logic       bsCapture,
  output logic       bsShift,
  output logic       bsUpdate
);
  tapState_e  ctrlState;
  tapStrobe_t strobe;
  tapMode_t   mode;
  logic       boundarySel;

  tapCtrl ctrl_i (
    .tck    (tck),
    .trstN  (trstN),
    .tmsIn  (tmsIn),
    .state  (ctrlState),
    .strobe (strobe)
  );

  tapData #(
    .HAS_ID     (HAS_ID),
    .ID_VERSION (ID_VERSION),
    .ID_PART    (ID_PART),
    .ID_MANUF   (ID_MANUF)
  ) data_i (
    .tck         (tck),
    .trstN       (trstN),
    .tdiIn       (tdiIn),
    .bsSerialIn  (bsSerialIn),
    .strobe      (strobe),
    .irValue     (irValue),
    .mode        (mode),
    .boundarySel (boundarySel),
    .tdoOut      (tdoOut),
    .tdoEn       (tdoEn)
  );

  assign modeExtest = mode.extest;
  assign modeSample = mode.sample;
  assign modeIntest = mode.intest;
  assign bsCapture  = strobe.capDr & boundarySel;
  assign bsShift    = strobe.shDr & boundarySel;
  assign bsUpdate   = strobe.updDr & boundarySel;
endmodule

// File: rtl/tapPortChk.sv
module tapPortChk
  import tapPkg::*;
(
  input logic       tck,
  input logic       trstN,
  input logic       tmsIn,
  input logic       tdoEn,
  input logic [3:0] irValue,
  input logic       modeExtest,
  input logic       modeSample,
  input logic       modeIntest,
  input logic       bsCapture,
  input logic       bsShift,
  input logic       bsUpdate,
  input tapState_e  ctrlState
);
  logic [2:0] onesRun;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            onesRun <= '0;
    else if (!tmsIn)       onesRun <= '0;
    else if (onesRun != 3'd5) onesRun <= onesRun + 3'd1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!trstN)
    (onesRun == 3'd5) |-> (ctrlState == ST_TLR)); // R3

  AST_IR_HOLD: assert property (@(posedge tck) disable iff (!trstN)
    (ctrlState != ST_UPD_IR && ctrlState != ST_TLR) |-> (irValue == $past(irValue))); // R5

  AST_MODE_ONEHOT: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({modeExtest, modeSample, modeIntest})); // R6

  AST_TDO_EN_SHIFT: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (ctrlState == ST_SH_IR || ctrlState == ST_SH_DR)); // R9

  AST_STROBE_EXCL: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({bsCapture, bsShift, bsUpdate})); // R10

  AST_STROBE_NEEDS_MODE: assert property (@(posedge tck) disable iff (!trstN)
    (bsCapture || bsShift || bsUpdate) |-> (modeExtest || modeSample || modeIntest)); // R10

  AST_CAPTURE_TO_SHIFT: assert property (@(posedge tck) disable iff (!trstN)
    (bsCapture && !tmsIn) |=> bsShift); // R1
endmodule

bind tapPort tapPortChk chk_i (
  .tck        (tck),
  .trstN      (trstN),
  .tmsIn      (tmsIn),
  .tdoEn      (tdoEn),
  .irValue    (irValue),
  .modeExtest (modeExtest),
  .modeSample (modeSample),
  .modeIntest (modeIntest),
  .bsCapture  (bsCapture),
  .bsShift    (bsShift),
  .bsUpdate   (bsUpdate),
  .ctrlState  (ctrlState)
);

// File: tb/tapPort_tb_top.sv
module tapPort_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam logic [3:0]  B_VER   = 4'h3;
  localparam logic [15:0] B_PART  = 16'hA5C2;
  localparam logic [10:0] B_MANUF = 11'h2B7;
  localparam logic [31:0] B_ID    = {B_VER, B_PART, B_MANUF, 1'b1};
  localparam logic [3:0]  B_RESET_OP = 4'b0010;

  typedef enum int {
    M_TLR, M_RTI, M_SEL_DR, M_CAP_DR, M_SH_DR, M_EX1_DR, M_PAU_DR, M_EX2_DR, M_UPD_DR,
    M_SEL_IR, M_CAP_IR, M_SH_IR, M_EX1_IR, M_PAU_IR, M_EX2_IR, M_UPD_IR
  } mst_e;

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tmsIn = 1'b1;
  logic tdiIn = 1'b0;
  logic bsSerialIn = 1'b0;
  logic tdoOut, tdoEn, modeExtest, modeSample, modeIntest, bsCapture, bsShift, bsUpdate;
  logic [3:0] irValue;

  int testCount = 0;
  int failCount = 0;
  int bsCount = 0;
  bit finished = 0;

  mst_e mState = M_TLR;
  logic [3:0]  irSh = 4'b0000;
  logic [3:0]  irPar = B_RESET_OP;
  logic        bpM = 1'b0;
  logic [31:0] idM = '0;
  logic        bsHold = 1'b0;

  tapPort dut_i (
    .tck(tck), .trstN(trstN), .tmsIn(tmsIn), .tdiIn(tdiIn), .bsSerialIn(bsSerialIn),
    .tdoOut(tdoOut), .tdoEn(tdoEn), .irValue(irValue),
    .modeExtest(modeExtest), .modeSample(modeSample), .modeIntest(modeIntest),
    .bsCapture(bsCapture), .bsShift(bsShift), .bsUpdate(bsUpdate)
  );

  always #(CLK_PERIOD/2) tck = ~tck;

  function automatic mst_e nextSt(mst_e s, bit t);
    case (s)
      M_TLR:    return t ? M_TLR    : M_RTI;
      M_RTI:    return t ? M_SEL_DR : M_RTI;
      M_SEL_DR: return t ? M_SEL_IR : M_CAP_DR;
      M_CAP_DR: return t ? M_EX1_DR : M_SH_DR;
      M_SH_DR:  return t ? M_EX1_DR : M_SH_DR;
      M_EX1_DR: return t ? M_UPD_DR : M_PAU_DR;
      M_PAU_DR: return t ? M_EX2_DR : M_PAU_DR;
      M_EX2_DR: return t ? M_UPD_DR : M_SH_DR;
      M_UPD_DR: return t ? M_SEL_DR : M_RTI;
      M_SEL_IR: return t ? M_TLR    : M_CAP_IR;
      M_CAP_IR: return t ? M_EX1_IR : M_SH_IR;
      M_SH_IR:  return t ? M_EX1_IR : M_SH_IR;
      M_EX1_IR: return t ? M_UPD_IR : M_PAU_IR;
      M_PAU_IR: return t ? M_EX2_IR : M_PAU_IR;
      M_EX2_IR: return t ? M_UPD_IR : M_SH_IR;
      default:  return t ? M_SEL_DR : M_RTI;
    endcase
  endfunction

  // {extest, sample, intest, idcode, bypass}
  function automatic logic [4:0] bDecode(logic [3:0] op);
    case (op)
      4'b0000: return 5'b10000;
      4'b1100: return 5'b01000;
      4'b1010: return 5'b00100;
      4'b0010: return 5'b00010;
      default: return 5'b00001;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input bit tms, input bit tdi, input bit bsNew, output bit tdoSeen);
    mst_e s;
    logic [4:0] md;
    bit bnd, expEn, expTdo;
    string tdoReq;
    @(negedge tck);
    #1;
    s = mState;
    if (s == M_UPD_IR) irPar = irSh;
    else if (s == M_TLR) irPar = B_RESET_OP;
    md = bDecode(irPar);
    bnd = md[4] | md[3] | md[2];
    expEn = (s == M_SH_IR) || (s == M_SH_DR);
    expTdo = 1'b0;
    tdoReq = "R9 idle";
    if (s == M_SH_IR) begin expTdo = irSh[0]; tdoReq = "R4 ir-shift"; end
    else if (s == M_SH_DR) begin
      if (md[1])      begin expTdo = idM[0]; tdoReq = "R8 id-shift"; end
      else if (md[0]) begin expTdo = bpM;    tdoReq = "R7 bypass-shift"; end
      else            begin expTdo = bsHold; tdoReq = "R9 boundary-shift"; end
    end
    chk("R1 R9 tdoEn", {31'b0, tdoEn}, {31'b0, expEn});
    chk(tdoReq, {31'b0, tdoOut}, {31'b0, expTdo});
    chk("R5 irValue", {28'b0, irValue}, {28'b0, irPar});
    chk("R6 modes", {29'b0, modeExtest, modeSample, modeIntest}, {29'b0, md[4:2]});
    chk("R10 strobes", {29'b0, bsCapture, bsShift, bsUpdate},
        {29'b0, (s == M_CAP_DR) && bnd, (s == M_SH_DR) && bnd, (s == M_UPD_DR) && bnd});
    if (bsShift) bsCount++;
    tdoSeen = tdoOut;
    tmsIn = tms;
    tdiIn = tdi;
    bsSerialIn = bsNew;
    bsHold = bsNew;
    @(posedge tck);
    if (s == M_CAP_IR) irSh = 4'b0101;
    else if (s == M_SH_IR) irSh = {tdi, irSh[3:1]};
    if (s == M_CAP_DR) begin
      bpM = 1'b0;
      if (md[1]) idM = B_ID;
    end else if (s == M_SH_DR) begin
      bpM = tdi;
      if (md[1]) idM = {tdi, idM[31:1]};
    end
    mState = nextSt(s, tms);
  endtask

  task automatic tk(input bit tms);
    bit d;
    tick(tms, 1'b0, 1'b0, d);
  endtask

  // from a shift state: n bits, last one leaves through Exit1, then Update and Run-Test/Idle
  task automatic scanBits(input int n, input logic [31:0] din, output logic [31:0] dout);
    bit o;
    dout = '0;
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], din[(i + 3) % 32], o);
      dout[i] = o;
    end
    tk(1'b1);
    tk(1'b0);
  endtask

  task automatic goIr(); tk(1); tk(1); tk(0); tk(0); endtask
  task automatic goDr(); tk(1); tk(0); tk(0); endtask

  task automatic loadIr(input logic [3:0] op, output logic [3:0] captured);
    logic [31:0] o;
    goIr();
    scanBits(4, {28'b0, op}, o);
    captured = o[3:0];
  endtask

  task automatic pulseReset();
    @(negedge tck);
    #5;
    tmsIn = 1'b1;
    trstN = 1'b0;
    #1;
    chk("R2 async ir", {28'b0, irValue}, {28'b0, B_RESET_OP});
    chk("R2 async tdoEn", {31'b0, tdoEn}, 32'd0);
    #2;
    trstN = 1'b1;
    mState = M_TLR;
    irPar = B_RESET_OP;
  endtask

  initial begin
    logic [31:0] o, o2;
    logic [3:0] cap;
    bit d;
    int seedDummy;
    seedDummy = $urandom(32'h5EED1);

    // reset state
    #(CLK_PERIOD * 2 + 3);
    chk("R2 reset ir", {28'b0, irValue}, {28'b0, B_RESET_OP});
    chk("R2 reset tdoEn", {31'b0, tdoEn}, 32'd0);
    chk("R6 reset modes", {29'b0, modeExtest, modeSample, modeIntest}, 32'd0);
    @(negedge tck);
    #4;
    trstN = 1'b1;
    tk(0);
    tk(0);

    // identification word after reset
    goDr();
    scanBits(32, 32'h1234_5678, o);
    chk("R8 idcode word", o, B_ID);

    // same read split by a pause
    goDr();
    for (int i = 0; i < 10; i++) begin tick(i == 9, 1'b1, 1'b0, d); o2[i] = d; end
    tk(0); tk(0); tk(0); tk(0);
    tk(1); tk(0);
    for (int i = 10; i < 32; i++) begin tick(i == 31, 1'b0, 1'b0, d); o2[i] = d; end
    tk(1); tk(0);
    chk("R11 paused id read", o2, B_ID);

    // instruction capture pattern and update timing
    loadIr(4'b1111, cap);
    chk("R4 ir capture", {28'b0, cap}, 32'h5);
    chk("R5 ir after update", {28'b0, irValue}, 32'hF);

    // bypass one-cycle delay with captured zero
    goDr();
    scanBits(8, 32'hB2, o);
    chk("R7 bypass delay", {24'b0, o[7:0]}, {24'b0, 8'hB2 << 1} & 32'hFF);

    // unlisted opcode acts as bypass
    loadIr(4'b0110, cap);
    chk("R6 unlisted modes", {29'b0, modeExtest, modeSample, modeIntest}, 32'd0);
    goDr();
    scanBits(6, 32'h2D, o);
    chk("R6 unlisted path", {26'b0, o[5:0]}, {26'b0, 6'h1A});

    // boundary instructions
    loadIr(4'b0000, cap);
    chk("R6 extest flag", {31'b0, modeExtest}, 32'd1);
    bsCount = 0;
    goDr();
    scanBits(12, 32'hA5C, o);
    chk("R10 shift strobe count", bsCount, 32'd12);
    loadIr(4'b1100, cap);
    chk("R6 sample flag", {31'b0, modeSample}, 32'd1);
    loadIr(4'b1010, cap);
    chk("R6 intest flag", {31'b0, modeIntest}, 32'd1);

    // five high TMS cycles from assorted states
    for (int k = 0; k < 8; k++) begin
      loadIr(4'b1111, cap);
      for (int j = 0; j < k * 2 + 1; j++) tick($urandom % 2, $urandom % 2, 1'b0, d);
      for (int j = 0; j < 6; j++) tk(1'b1);
      chk("R3 five ones reset", {28'b0, irValue}, {28'b0, B_RESET_OP});
      tk(0);
    end

    // asynchronous reset in the middle of a data scan
    loadIr(4'b1111, cap);
    goDr();
    tk(0); tk(0);
    pulseReset();
    tk(0);

    // random walk
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 400 == 0) pulseReset();
      else tick(($urandom % 100) < 35, $urandom % 2, $urandom % 2, d);
    end

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      failCount++;
      testCount++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule